// File: doc/BRIEF.md
# Saturating Counter Branch Predictor

This block is a branch prediction buffer: a table of saturating counters, one per entry, selected by the low-order word-address bits of a branch's program counter. A fetch stage presents a PC on the lookup port and gets a taken / not-taken guess back in the same cycle, with no register between the PC and the guess. Later, when the branch resolves, the execute stage sends the same PC and the real outcome on the update port. The selected counter then moves one step towards that outcome and stops at either end of its range.

The counter width is a parameter. A counter of width n counts from 0 to 2^n - 1, and it predicts taken once twice its value reaches that maximum. With the default width of 2 this gives the usual four-state scheme with hysteresis. A branch that is strongly biased needs two contrary outcomes before its prediction changes. The number of entries is also a parameter and must be a power of two. Tags, targets, history and return prediction are not part of this block, so different branches that share index bits also share a counter.

Top module: `branch_bias_predictor`

## Requirements
- R1: While rstN is low, every counter is set to 2^(CTR_W-1) - 1. This is the largest value that still predicts not taken, so after reset every lookup predicts not taken, and one taken update moves any entry to predicting taken.
- R2: An update with updValid=1 and updTaken=1 adds one to the selected counter when it is below 2^CTR_W - 1.
- R3: A taken update on a counter already at 2^CTR_W - 1 leaves it at that value, so the counter never wraps to zero.
- R4: An update with updTaken=0 subtracts one from the selected counter when it is above 0, and leaves a counter at 0 unchanged.
- R5: predictTaken is 1 exactly when 2 * counter >= 2^CTR_W - 1, for the counter selected by lookupPc.
- R6: For both lookupPc and updPc, the entry is selected by bits [log2(ENTRIES)+1:2] only. Bits [1:0] and all bits above the index field have no effect.
- R7: predictTaken depends combinationally on lookupPc. If an update hits the entry being looked up in the same cycle, the lookup shows the value from before the update, and the new value appears after the next rising clock edge.
- R8: When updValid is 0, no counter changes, whatever updPc and updTaken are.
- R9: With CTR_W = 2, an entry at the maximum count still predicts taken after one not-taken update, and predicts not taken only after a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| lookupPc | input | PC_W | PC of the branch being predicted |
| predictTaken | output | 1 | Same-cycle prediction for lookupPc |
| updValid | input | 1 | Resolved outcome present this cycle |
| updPc | input | PC_W | PC of the resolved branch |
| updTaken | input | 1 | Resolved direction, 1 = taken |

## Verification
From the ports, a counter can only be seen through one threshold bit. Because of that, saturation at both ends and the exact reset value are hard to observe directly. The bench keeps an arithmetic model of every counter and drives single entries far past either end. It then walks them back one outcome at a time, so a wrap or an off-by-one step shows up as a prediction flipping too early or too late. To test the same-cycle case and the ignored PC bits, each update also looks up its own entry through a differently aliased PC, both before and after the clock edge. After every step the bench sweeps all entries.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // Strobes from the control block to the counter table
  typedef struct packed {
    logic write;
    logic stepUp;
    logic stepDown;
  } ctrStrobe_t;

endpackage

// File: rtl/bp_ctrl.sv
module bp_ctrl
  import bp_pkg::*;
#(
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             updValid,
  input  logic             updTaken,
  input  logic [CTR_W-1:0] updCount,
  input  logic [CTR_W-1:0] lookCount,
  output ctrStrobe_t       strobe,
  output logic             predictTaken
);

  localparam logic [CTR_W-1:0] MAX_CNT = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] MIN_CNT = '0;
  localparam logic [CTR_W:0]   MAX_EXT = {1'b0, MAX_CNT};

  logic atMax;
  logic atMin;
  logic [CTR_W:0] lookDouble;

  assign atMax = (updCount == MAX_CNT);
  assign atMin = (updCount == MIN_CNT);

  // Saturation is decided here; the table only applies the step it is given
  always_comb begin
    strobe = '0;
    if (updValid) begin
      if (updTaken && !atMax) begin
        strobe.write  = 1'b1;
        strobe.stepUp = 1'b1;
      end else if (!updTaken && !atMin) begin
        strobe.write    = 1'b1;
        strobe.stepDown = 1'b1;
      end
    end
  end

  // Predict taken when twice the count reaches the maximum count
  assign lookDouble   = {lookCount, 1'b0};
  assign predictTaken = (lookDouble >= MAX_EXT);

  // R2: only one direction of step at a time, and every write carries a direction
  p_one_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.write |-> $onehot0({strobe.stepUp, strobe.stepDown}) && (strobe.stepUp || strobe.stepDown));

  // R8: nothing is written without a resolved outcome
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |-> !strobe.write);

endmodule

// File: rtl/bp_table.sv
module bp_table
  import bp_pkg::*;
#(
  parameter int CTR_W   = 2,
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] lookIdx,
  output logic [CTR_W-1:0] lookCount,
  input  logic [IDX_W-1:0] updIdx,
  output logic [CTR_W-1:0] updCount,
  input  ctrStrobe_t       strobe
);

  localparam logic [CTR_W-1:0] MAX_CNT  = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] WEAK_CNT = CTR_W'((1 << (CTR_W - 1)) - 1);

  logic [CTR_W-1:0] cells [ENTRIES];
  logic [ENTRIES-1:0] entrySel;

  // One-hot select of the updated entry
  always_comb begin
    entrySel = '0;
    entrySel[updIdx] = strobe.write;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cells[e] <= WEAK_CNT;
      end else if (entrySel[e]) begin
        if (strobe.stepUp) begin
          cells[e] <= cells[e] + 1'b1;
        end else if (strobe.stepDown) begin
          cells[e] <= cells[e] - 1'b1;
        end
      end
    end
  end

  // Two independent read ports; both return the value held before the edge
  assign lookCount = cells[lookIdx];
  assign updCount  = cells[updIdx];

  // R3: an entry already at the top stays at the top
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (updCount == MAX_CNT) |=> (cells[$past(updIdx)] == MAX_CNT) || $past(strobe.stepDown));

  // R4: an entry at zero stays at zero
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    (updCount == '0) |=> (cells[$past(updIdx)] == '0) || $past(strobe.stepUp));

  // R2: a step up moves the entry by exactly one
  p_step_up_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.write && strobe.stepUp) |=> cells[$past(updIdx)] == CTR_W'($past(updCount) + 1'b1));

  // R4: a step down moves the entry by exactly one
  p_step_down_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.write && strobe.stepDown) |=> cells[$past(updIdx)] == CTR_W'($past(updCount) - 1'b1));

endmodule

// File: rtl/branch_bias_predictor.sv
module branch_bias_predictor
  import bp_pkg::*;
#(
  parameter int CTR_W   = 2,
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lookupPc,
  output logic            predictTaken,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_W + IDX_LO - 1;

  logic [IDX_W-1:0] lookIdx;
  logic [IDX_W-1:0] updIdx;
  logic [CTR_W-1:0] lookCount;
  logic [CTR_W-1:0] updCount;
  ctrStrobe_t       strobe;
  logic             unusedPcBits;

  // Word-aligned PCs: drop the byte offset, keep the low word-address bits
  assign lookIdx = lookupPc[IDX_HI:IDX_LO];
  assign updIdx  = updPc[IDX_HI:IDX_LO];
  assign unusedPcBits = ^{lookupPc[PC_W-1:IDX_HI+1], lookupPc[IDX_LO-1:0],
                          updPc[PC_W-1:IDX_HI+1], updPc[IDX_LO-1:0]};

  bp_table #(
    .CTR_W  (CTR_W),
    .ENTRIES(ENTRIES),
    .IDX_W  (IDX_W)
  ) u_table (
    .clk      (clk),
    .rstN     (rstN),
    .lookIdx  (lookIdx),
    .lookCount(lookCount),
    .updIdx   (updIdx),
    .updCount (updCount),
    .strobe   (strobe)
  );

  bp_ctrl #(
    .CTR_W(CTR_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .updValid    (updValid),
    .updTaken    (updTaken),
    .updCount    (updCount),
    .lookCount   (lookCount),
    .strobe      (strobe),
    .predictTaken(predictTaken)
  );

  // R7: with no update, the prediction for a held lookup PC does not move
  p_lookup_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!updValid && $stable(lookupPc)) |=> $stable(predictTaken) || !$stable(lookupPc));

endmodule

// File: tb/branch_bias_predictor_test.sv
`timescale 1ns/1ps
module branch_bias_predictor_test;

  localparam int CTR_W   = 2;
  localparam int ENTRIES = 8;
  localparam int PC_W    = 16;
  localparam int IDX_W   = 3;
  localparam int MAXV    = (1 << CTR_W) - 1;
  localparam int WEAKV   = (1 << (CTR_W - 1)) - 1;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [PC_W-1:0] lookupPc = '0;
  logic            predictTaken;
  logic            updValid = 1'b0;
  logic [PC_W-1:0] updPc = '0;
  logic            updTaken = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int model [ENTRIES];
  int unsigned seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  branch_bias_predictor #(
    .CTR_W(CTR_W), .ENTRIES(ENTRIES), .PC_W(PC_W)
  ) uut (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .predictTaken(predictTaken),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken)
  );

  function automatic int unsigned nextRand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 8;
  endfunction

  function automatic bit expPred(int e);
    return (2 * model[e]) >= MAXV;
  endfunction

  // Build a PC for an entry with random bits outside the index field (R6)
  function automatic logic [PC_W-1:0] makePc(int e);
    logic [PC_W-1:0] p;
    p = PC_W'(nextRand());
    p[IDX_W+1:2] = IDX_W'(e);
    return p;
  endfunction

  task automatic check(string tag, bit got, bit exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic sweep(string tag);
    for (int e = 0; e < ENTRIES; e++) begin
      lookupPc = makePc(e);
      #0.1;
      check(tag, predictTaken, expPred(e));
    end
  endtask

  task automatic doUpdate(int e, bit taken, string tag);
    @(negedge clk);
    updValid = 1'b1;
    updPc    = makePc(e);
    updTaken = taken;
    lookupPc = makePc(e);
    #1;
    // R7: same-cycle lookup sees the value before the update
    check("R7", predictTaken, expPred(e));
    @(posedge clk);
    #1;
    if (taken && model[e] < MAXV) model[e]++;
    else if (!taken && model[e] > 0) model[e]--;
    updValid = 1'b0;
    check(tag, predictTaken, expPred(e));
    @(negedge clk);
    #1;
    sweep(tag);
  endtask

  initial begin
    for (int e = 0; e < ENTRIES; e++) model[e] = WEAKV;
    // Reset with a pending update: reset must win (R1)
    updValid = 1'b1; updTaken = 1'b1; updPc = makePc(2);
    repeat (4) @(posedge clk);
    @(negedge clk);
    updValid = 1'b0;
    rstN = 1'b1;
    #1;
    sweep("R1");

    // R1: one taken outcome flips a freshly reset entry
    doUpdate(5, 1'b1, "R1");

    // R2/R3: drive entry 3 past the top
    doUpdate(3, 1'b1, "R2");
    doUpdate(3, 1'b1, "R2");
    for (int k = 0; k < 3; k++) doUpdate(3, 1'b1, "R3");
    // R9: one contrary outcome keeps the prediction, the second flips it
    doUpdate(3, 1'b0, "R9");
    doUpdate(3, 1'b0, "R9");
    // R4: drive down past zero, then back up one step at a time
    for (int k = 0; k < 4; k++) doUpdate(3, 1'b0, "R4");
    doUpdate(3, 1'b1, "R4");
    doUpdate(3, 1'b1, "R2");

    // R8: wiggle update inputs with updValid low
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      updValid = 1'b0;
      updPc    = makePc(k % ENTRIES);
      updTaken = k[0];
    end
    @(negedge clk);
    #1;
    sweep("R8");

    // R5/R6: random aliased updates over all entries
    for (int k = 0; k < 300; k++) begin
      int unsigned r;
      r = nextRand();
      doUpdate(int'(r % ENTRIES), r[9] | r[10], (k % 2 == 0) ? "R5" : "R6");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #900000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog got=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule